// File: doc/BRIEF.md
# Recirculating Loop Packet Buffer

This block holds one fixed-length serial packet in a closed storage loop. The loop is built from a two-by-two crossbar, one retiming register stage and a fixed delay. The crossbar has two inputs: the external serial input and the bit returning from the loop. It has two outputs: the external serial output and the head of the loop. A per-clock select input picks between two connections. In the straight state, incoming traffic bypasses the loop and the stored packet circulates unchanged. In the swapped state, incoming bits go into the loop and stored bits leave toward the output.

The retiming register captures both crossbar outputs on every rising clock edge. The delay behind it is a chain of LOOP_LEN-1 flops, so a bit takes exactly LOOP_LEN clocks to travel once around the loop. A packet is loaded by holding the swapped state for one packet period. It is released by a later swapped period. Each straight period in between keeps it for one more packet period. Each lane is DATA_W bits wide, so parallel traffic can share one loop per lane group.

Top module: `loop_pkt_buf`

## Requirements
- R1: With sel=0 (straight), the dout value after a rising edge equals the din value sampled at that edge. This is a one-clock retimed bypass.
- R2: With sel=0, the bit returning from the loop is written back into the loop head unchanged, so stored data survives any number of straight periods.
- R3: With sel=1 (swapped), din is written into the loop head, and the bit returning from the loop is presented at dout after the same edge.
- R4: The select encoding is 1 for swapped and 0 for straight, and it is sampled on every clock.
- R5: A bit written into the loop at edge k returns from the loop at edge k+LOOP_LEN. One of those LOOP_LEN clocks is the retiming register; the other LOOP_LEN-1 clocks are the delay chain.
- R6: Setting LOOP_LEN=40 gives a 40-bit buffer with the same behaviour. No other change is needed.
- R7: Holding sel=1 for two consecutive packet periods stores a packet during the first period and delivers it, bit for bit and in order, during the second.
- R8: Setting sel=1 for one period, sel=0 for the next, and sel=1 for a third delivers the packet in the third period, after a hold of two packet periods.
- R9: During a swapped period that delivers a stored packet, a new packet is loaded in the same clocks, with no bit lost or repeated.
- R10: A synchronous active-high rst clears dout and every loop bit to zero, so a swapped period right after reset delivers all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Crossbar select per clock: 1 = swapped, 0 = straight |
| din | input | DATA_W | Serial data input |
| dout | output | DATA_W | Serial data output, registered |

## Verification
The hardest situation to reach from the ports is a loop that holds a packet while every slot is also being overwritten. A swapped period must then exchange an old packet for a new one with the phase of every bit kept. The stimulus reaches this with back-to-back swapped periods that carry two different packets, followed by a swapped period of zeros. A cycle model with a circular slot array predicts every output bit. A second instance with a 40-clock loop runs under the same traffic, so the loop length cannot be hidden in a fixed constant. Long pseudo-random runs of select and data then cover irregular mixes of partial periods.

// File: rtl/lrb_pkg.sv
`timescale 1ns/1ps
package lrb_pkg;
   typedef enum logic {
      XB_STRAIGHT = 1'b0,
      XB_SWAP     = 1'b1
   } xbar_mode_e;
endpackage

// File: rtl/lrb_crossbar.sv
`timescale 1ns/1ps
module lrb_crossbar
   import lrb_pkg::*;
#(
   parameter int W = 1
) (
   input  xbar_mode_e     mode,
   input  logic [W-1:0]   ext_in,
   input  logic [W-1:0]   ring_in,
   output logic [W-1:0]   ext_out,
   output logic [W-1:0]   ring_out
);
   always_comb begin
      case (mode)
         XB_SWAP: begin
            ext_out  = ring_in;
            ring_out = ext_in;
         end
         default: begin
            ext_out  = ext_in;
            ring_out = ring_in;
         end
      endcase
   end
endmodule

// File: rtl/lrb_retime.sv
`timescale 1ns/1ps
module lrb_retime #(
   parameter int W = 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [W-1:0]   ext_d,
   input  logic [W-1:0]   ring_d,
   output logic [W-1:0]   ext_q,
   output logic [W-1:0]   ring_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ext_q  <= '0;
         ring_q <= '0;
      end else begin
         ext_q  <= ext_d;
         ring_q <= ring_d;
      end
   end
endmodule

// File: rtl/lrb_delay_chain.sv
`timescale 1ns/1ps
module lrb_delay_chain #(
   parameter int W     = 1,
   parameter int DEPTH = 31
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [W-1:0]   d,
   output logic [W-1:0]   q
);
   localparam int LAST = DEPTH - 1;

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] stg;
         always_ff @(posedge clk) begin
            if (rst) stg <= '0;
            else     stg <= d;
         end
         assign q = stg;
      end else begin : g_chain
         logic [W-1:0] stg [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) stg[0] <= '0;
            else     stg[0] <= d;
         end
         for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst) stg[i] <= '0;
               else     stg[i] <= stg[i-1];
            end
         end
         assign q = stg[LAST];
      end
   endgenerate

   AST_TAIL_CLEARED: assert property (@(posedge clk) rst |=> (q == '0)) else $error("tail not cleared"); // R10
endmodule

// File: rtl/loop_pkt_buf.sv
`timescale 1ns/1ps
module loop_pkt_buf
   import lrb_pkg::*;
#(
   parameter int DATA_W   = 1,
   parameter int LOOP_LEN = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int CHAIN_DEPTH = LOOP_LEN - 1;

   generate
      if (LOOP_LEN < 2) begin : g_bad_len
         $error("LOOP_LEN must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   xbar_mode_e        mode;
   logic [DATA_W-1:0] xb_ext;
   logic [DATA_W-1:0] xb_ring;
   logic [DATA_W-1:0] ring_head;
   logic [DATA_W-1:0] ring_tail;

   assign mode = xbar_mode_e'(sel);

   lrb_crossbar #(.W(DATA_W)) xbar_i (
      .mode     (mode),
      .ext_in   (din),
      .ring_in  (ring_tail),
      .ext_out  (xb_ext),
      .ring_out (xb_ring)
   );

   lrb_retime #(.W(DATA_W)) retime_i (
      .clk    (clk),
      .rst    (rst),
      .ext_d  (xb_ext),
      .ring_d (xb_ring),
      .ext_q  (dout),
      .ring_q (ring_head)
   );

   lrb_delay_chain #(.W(DATA_W), .DEPTH(CHAIN_DEPTH)) delay_i (
      .clk (clk),
      .rst (rst),
      .d   (ring_head),
      .q   (ring_tail)
   );

   AST_STRAIGHT_BYPASS: assert property (@(posedge clk) disable iff (rst)
      !sel |=> (dout == $past(din))) else $error("bypass broken"); // R1
   AST_STRAIGHT_RECIRC: assert property (@(posedge clk) disable iff (rst)
      !sel |=> (ring_head == $past(ring_tail))) else $error("recirculation broken"); // R2
   AST_SWAP_LOAD: assert property (@(posedge clk) disable iff (rst)
      sel |=> (ring_head == $past(din))) else $error("load broken"); // R3
   AST_SWAP_DELIVER: assert property (@(posedge clk) disable iff (rst)
      sel |=> (dout == $past(ring_tail))) else $error("delivery broken"); // R3
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (dout == '0 && ring_head == '0)) else $error("reset not clearing"); // R10
endmodule

// File: tb/loop_pkt_buf_tb.sv
`timescale 1ns/1ps
module loop_pkt_buf_tb_top;
   localparam logic [31:0] PAT = 32'hFF55_330F;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sel = 1'b0;
   logic din = 1'b0;
   logic dout32;
   logic dout40;

   always #2.5 clk = ~clk;

   loop_pkt_buf #(.DATA_W(1), .LOOP_LEN(32)) dut_i (
      .clk(clk), .rst(rst), .sel(sel), .din(din), .dout(dout32));
   loop_pkt_buf #(.DATA_W(1), .LOOP_LEN(40)) dut40_i (
      .clk(clk), .rst(rst), .sel(sel), .din(din), .dout(dout40));

   int n_cmp = 0;
   int n_bad = 0;
   logic m32 [32];
   logic m40 [40];
   int p32 = 0;
   int p40 = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; sel = 1'b0; din = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk(dout32, 1'b0, "R10 reset dout L32");
      chk(dout40, 1'b0, "R10 reset dout L40");
      for (int i = 0; i < 32; i++) m32[i] = 1'b0;
      for (int i = 0; i < 40; i++) m40[i] = 1'b0;
      p32 = 0; p40 = 0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // one clock: drive, let the edge happen, compare with the slot model
   task automatic step(input logic d, input logic s, input string tag);
      logic e32, e40;
      @(negedge clk);
      din = d; sel = s;
      @(posedge clk);
      #1;
      e32 = s ? m32[p32] : d;
      e40 = s ? m40[p40] : d;
      if (s) begin
         m32[p32] = d;
         m40[p40] = d;
      end
      p32 = (p32 + 1) % 32;
      p40 = (p40 + 1) % 40;
      chk(dout32, e32, {tag, " L32"});
      chk(dout40, e40, {tag, " L40"});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      do_reset();

      // R10: empty loop delivers zeros
      for (int i = 0; i < 32; i++) step(1'b1, 1'b1, "R10 empty swap");

      // R1 R4: straight state passes the pattern through, MSB first
      do_reset();
      for (int i = 0; i < 32; i++) begin
         step(PAT[31-i], 1'b0, "R1 bypass");
         chk(dout32, PAT[31-i], "R4 sel0 straight");
      end

      // R7: load in one swapped period, deliver in the next
      do_reset();
      for (int i = 0; i < 32; i++) step(PAT[31-i], 1'b1, "R7 load");
      for (int i = 0; i < 32; i++) begin
         step(1'b0, 1'b1, "R7 deliver");
         chk(dout32, PAT[31-i], "R7 packet out");
      end

      // R8 R2: hold across a straight period fed with other traffic
      do_reset();
      for (int i = 0; i < 32; i++) step(PAT[31-i], 1'b1, "R8 load");
      for (int i = 0; i < 32; i++) begin
         step(~PAT[31-i], 1'b0, "R2 straight hold");
         chk(dout32, ~PAT[31-i], "R2 bypass during hold");
      end
      for (int i = 0; i < 32; i++) begin
         step(1'b0, 1'b1, "R8 deliver");
         chk(dout32, PAT[31-i], "R8 packet after 64");
      end

      // R9: swap a new packet in while the old one leaves
      do_reset();
      for (int i = 0; i < 32; i++) step(PAT[31-i], 1'b1, "R9 load A");
      for (int i = 0; i < 32; i++) begin
         step(PAT[i], 1'b1, "R9 swap");
         chk(dout32, PAT[31-i], "R9 A out");
      end
      for (int i = 0; i < 32; i++) begin
         step(1'b0, 1'b1, "R9 drain");
         chk(dout32, PAT[i], "R9 B out");
      end

      // R6: 40-clock periods on the longer loop
      do_reset();
      for (int i = 0; i < 40; i++) step(PAT[(71-i)%32], 1'b1, "R6 load");
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R6 hold");
      for (int i = 0; i < 40; i++) begin
         step(1'b0, 1'b1, "R6 deliver");
         chk(dout40, PAT[(71-i)%32], "R6 L40 packet");
      end

      // R5 R3: irregular select and data
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], lfsr[3] | lfsr[7], "R5 R3 random");
      end

      // R10: reset in mid-storage discards the packet
      for (int i = 0; i < 32; i++) step(1'b1, 1'b1, "R10 prefill");
      do_reset();
      for (int i = 0; i < 40; i++) step(1'b0, 1'b1, "R10 cleared loop");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule